// File: doc/BRIEF.md
# Private Transfer Queue Bridge

This block sits between the byte engine of an I3C target and four software-visible queues. During a private write it collects the bytes the controller sends. It packs them four to a 32-bit word, least significant byte first, and pushes the words into an RX data queue. When the write ends, it pushes one RX descriptor that carries the number of bytes it kept. Software reads that descriptor first and then the words it describes. For this reason the descriptor is pushed only after every data word of the same transfer has been accepted.

During a private read, the bus engine raises a start pulse at the address phase. If a TX descriptor is waiting, the bridge acknowledges the read and pops the descriptor, which sets a byte limit. It then unpacks words from the TX data queue into a byte stream. The read stops with an end-of-data pulse when the limit is used up or when the data queue is empty at the moment a new word is needed. If no descriptor is waiting, the read is refused.

Every queue port is valid/ready. A push holds valid and data until ready is seen, and a pop completes only in a cycle where both valid and ready are high. The write byte input cannot be stalled: a byte that arrives while the RX data queue reports not-ready is lost and recorded in a sticky overflow flag. The read byte output is valid/ready, and the bus engine applies back-pressure with `rb_ready`. The remaining pins are plain control and status.

Top module: `ptq_bridge`

## Requirements
- R1: A write byte is kept when `wb_valid` is high, `wr_busy` is low and `rxq_ready` is high. Kept bytes fill a 32-bit word little-endian (the first byte in bits [7:0]). Each completed word is pushed on the RX data port.
- R2: If a write ends with 1 to 3 bytes in the unfinished word, that word is pushed with its unused upper bytes set to zero.
- R3: After each write, exactly one RX descriptor is pushed, holding the count of kept bytes in bits [15:0] with bits [31:16] zero. A write with no bytes still produces a count of zero. While the descriptor is offered, no data word of the transfer is outstanding.
- R4: A byte presented in the same cycle as `wr_end` belongs to the transfer that is ending.
- R5: A write byte offered while `rxq_ready` is low is discarded and not counted, and `overflow` rises. `overflow` stays high until `ovf_clear` is pulsed; a new drop in the clearing cycle keeps it high.
- R6: `wr_busy` is high from the cycle after `wr_end` until the descriptor is accepted. Bytes offered during that time are ignored: they are not stored, not counted and do not set `overflow`.
- R7: Both RX push ports keep valid high and data unchanged while ready is low.
- R8: When `rd_start` arrives with a TX descriptor waiting, `rd_ack` is high in that cycle and the descriptor is popped. With none waiting, `rd_ack` is low, nothing is popped and no byte follows.
- R9: Read bytes come out least significant byte first from each popped TX word, one per `rb_valid`/`rb_ready` handshake, and each byte is held while `rb_ready` is low.
- R10: A read delivers at most the byte count in descriptor bits [15:0], then pulses `rd_eod` for one cycle. A limit of zero delivers no byte. Bytes left over in a partly used word are discarded.
- R11: If the TX data queue is empty when the read needs a new word, the read ends with `rd_eod`.
- R12: `rd_end` ends a read at once. The bridge returns to idle and discards any word it holds, and the next read starts from the next word in the queue.
- R13: After reset no push or byte is offered, and `overflow`, `wr_busy` and `rd_eod` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wb_valid | input | 1 | A write byte is present this cycle |
| wb_data | input | 8 | Write byte |
| wr_end | input | 1 | Pulse: write ended (STOP or repeated START) |
| wr_busy | output | 1 | Finishing a write; new bytes are ignored |
| overflow | output | 1 | Sticky flag: a write byte was dropped |
| ovf_clear | input | 1 | Pulse that clears `overflow` |
| rxq_valid | output | 1 | RX data push valid |
| rxq_data | output | 32 | RX data word |
| rxq_ready | input | 1 | RX data queue can accept |
| rxd_valid | output | 1 | RX descriptor push valid |
| rxd_data | output | 32 | RX descriptor (byte count in [15:0]) |
| rxd_ready | input | 1 | RX descriptor queue can accept |
| rd_start | input | 1 | Pulse: private read addressed to this target |
| rd_ack | output | 1 | Read accepted (descriptor available) |
| rd_end | input | 1 | Pulse: controller ended the read |
| rd_eod | output | 1 | Pulse: no more read data |
| rb_valid | output | 1 | Read byte valid |
| rb_data | output | 8 | Read byte |
| rb_ready | input | 1 | Bus engine takes the read byte |
| txd_valid | input | 1 | TX descriptor available |
| txd_data | input | 32 | TX descriptor (byte limit in [15:0]) |
| txd_ready | output | 1 | TX descriptor pop |
| txq_valid | input | 1 | TX data word available |
| txq_data | input | 32 | TX data word |
| txq_ready | output | 1 | TX data pop |

## Verification
The final write byte and the end-of-transfer marker can land in the same cycle. In that case one edge must both store the byte and choose between flushing a partial word and going straight to the descriptor. The bench raises `wr_end` together with the last byte of a five-byte write. It then requires a zero-padded second word holding exactly that byte, followed by a descriptor count of five. Both the word and the count are compared in order by the scoreboard against a byte model kept in the bench.

// File: rtl/ptq_pkg.sv
package ptq_pkg;
  typedef enum logic [1:0] {
    WR_COLLECT,
    WR_FLUSH,
    WR_DRAIN,
    WR_DESC
  } wr_state_e;

  typedef enum logic {
    RD_IDLE,
    RD_RUN
  } rd_state_e;
endpackage

// File: rtl/ptq_rx_packer.sv
module ptq_rx_packer #(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wb_valid,
  input  logic [7:0]        wb_data,
  input  logic              wr_end,
  input  logic              ovf_clear,
  output logic              wr_busy,
  output logic              overflow,
  output logic              rxq_valid,
  output logic [WORD_W-1:0] rxq_data,
  input  logic              rxq_ready,
  output logic              rxd_valid,
  output logic [WORD_W-1:0] rxd_data,
  input  logic              rxd_ready
);
  import ptq_pkg::*;

  localparam int BYTES  = WORD_W / 8;
  localparam int LANE_W = (BYTES > 1) ? $clog2(BYTES) : 1;
  localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(BYTES - 1);

  wr_state_e         st;
  logic [WORD_W-1:0] acc, acc_ins, out_d;
  logic [LANE_W-1:0] lane, lane_nx;
  logic [CNT_W-1:0]  cnt;
  logic              out_v, ovf;
  logic              collecting, take, drop, word_full;
  logic [BYTES-1:0]  lane_hit;

  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    assign lane_hit[g] = (lane == LANE_W'(g));
  end

  // New byte goes in its lane; the first byte of a word clears the rest.
  always_comb begin
    for (int i = 0; i < BYTES; i++) begin
      acc_ins[i*8 +: 8] = lane_hit[i] ? wb_data :
                          ((lane == '0) ? 8'h00 : acc[i*8 +: 8]);
    end
  end

  assign collecting = (st == WR_COLLECT);
  assign take       = wb_valid & collecting & rxq_ready;
  assign drop       = wb_valid & collecting & ~rxq_ready;
  assign word_full  = take & (lane == LAST_LANE);
  assign lane_nx    = take ? (word_full ? '0 : lane + 1'b1) : lane;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= WR_COLLECT;
      acc   <= '0;
      out_d <= '0;
      out_v <= 1'b0;
      lane  <= '0;
      cnt   <= '0;
      ovf   <= 1'b0;
    end else begin
      if (out_v && rxq_ready) out_v <= 1'b0;
      if (drop)           ovf <= 1'b1;
      else if (ovf_clear) ovf <= 1'b0;
      case (st)
        WR_COLLECT: begin
          if (take) begin
            acc  <= acc_ins;
            cnt  <= cnt + 1'b1;
            lane <= lane_nx;
            if (word_full) begin
              out_d <= acc_ins;
              out_v <= 1'b1;
            end
          end
          if (wr_end) st <= (lane_nx != '0) ? WR_FLUSH : WR_DRAIN;
        end
        WR_FLUSH: begin
          if (!out_v || rxq_ready) begin
            out_d <= acc;
            out_v <= 1'b1;
            lane  <= '0;
            st    <= WR_DRAIN;
          end
        end
        WR_DRAIN: begin
          if (!out_v) st <= WR_DESC;
        end
        WR_DESC: begin
          if (rxd_ready) begin
            cnt <= '0;
            st  <= WR_COLLECT;
          end
        end
        default: st <= WR_COLLECT;
      endcase
    end
  end

  assign wr_busy   = ~collecting;
  assign overflow  = ovf;
  assign rxq_valid = out_v;
  assign rxq_data  = out_d;
  assign rxd_valid = (st == WR_DESC);
  assign rxd_data  = WORD_W'(cnt);
endmodule

// File: rtl/ptq_tx_unpacker.sv
module ptq_tx_unpacker #(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_start,
  output logic              rd_ack,
  input  logic              rd_end,
  output logic              rd_eod,
  output logic              rb_valid,
  output logic [7:0]        rb_data,
  input  logic              rb_ready,
  input  logic              txd_valid,
  input  logic [CNT_W-1:0]  txd_limit,
  output logic              txd_ready,
  input  logic              txq_valid,
  input  logic [WORD_W-1:0] txq_data,
  output logic              txq_ready
);
  import ptq_pkg::*;

  localparam int BYTES  = WORD_W / 8;
  localparam int LANE_W = (BYTES > 1) ? $clog2(BYTES) : 1;
  localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(BYTES - 1);

  rd_state_e         st;
  logic [WORD_W-1:0] word;
  logic              have;
  logic [LANE_W-1:0] lane;
  logic [CNT_W-1:0]  remain;
  logic [7:0]        lane_byte [BYTES];
  logic              running, exhausted, byte_fire;

  for (genvar g = 0; g < BYTES; g++) begin : g_sel
    assign lane_byte[g] = word[g*8 +: 8];
  end

  assign running   = (st == RD_RUN);
  assign exhausted = running & ((remain == '0) | (~have & ~txq_valid));
  assign rd_ack    = (st == RD_IDLE) & txd_valid;
  assign txd_ready = rd_start & rd_ack;
  assign txq_ready = running & ~have & (remain != '0) & ~rd_end;
  assign rb_valid  = running & have & (remain != '0) & ~rd_end;
  assign rb_data   = lane_byte[lane];
  assign rd_eod    = exhausted;
  assign byte_fire = rb_valid & rb_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= RD_IDLE;
      word   <= '0;
      have   <= 1'b0;
      lane   <= '0;
      remain <= '0;
    end else begin
      case (st)
        RD_IDLE: begin
          if (txd_ready) begin
            remain <= txd_limit;
            have   <= 1'b0;
            lane   <= '0;
            st     <= RD_RUN;
          end
        end
        RD_RUN: begin
          if (rd_end || exhausted) begin
            have <= 1'b0;
            st   <= RD_IDLE;
          end else begin
            if (txq_ready && txq_valid) begin
              word <= txq_data;
              have <= 1'b1;
              lane <= '0;
            end
            if (byte_fire) begin
              remain <= remain - 1'b1;
              lane   <= lane + 1'b1;
              if (lane == LAST_LANE) have <= 1'b0;
            end
          end
        end
        default: st <= RD_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ptq_bridge.sv
module ptq_bridge #(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wb_valid,
  input  logic [7:0]        wb_data,
  input  logic              wr_end,
  output logic              wr_busy,
  output logic              overflow,
  input  logic              ovf_clear,
  output logic              rxq_valid,
  output logic [WORD_W-1:0] rxq_data,
  input  logic              rxq_ready,
  output logic              rxd_valid,
  output logic [WORD_W-1:0] rxd_data,
  input  logic              rxd_ready,
  input  logic              rd_start,
  output logic              rd_ack,
  input  logic              rd_end,
  output logic              rd_eod,
  output logic              rb_valid,
  output logic [7:0]        rb_data,
  input  logic              rb_ready,
  input  logic              txd_valid,
  input  logic [WORD_W-1:0] txd_data,
  output logic              txd_ready,
  input  logic              txq_valid,
  input  logic [WORD_W-1:0] txq_data,
  output logic              txq_ready
);
  logic unused_desc_hi;
  assign unused_desc_hi = ^txd_data[WORD_W-1:CNT_W];

  ptq_rx_packer #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .wb_valid  (wb_valid),
    .wb_data   (wb_data),
    .wr_end    (wr_end),
    .ovf_clear (ovf_clear),
    .wr_busy   (wr_busy),
    .overflow  (overflow),
    .rxq_valid (rxq_valid),
    .rxq_data  (rxq_data),
    .rxq_ready (rxq_ready),
    .rxd_valid (rxd_valid),
    .rxd_data  (rxd_data),
    .rxd_ready (rxd_ready)
  );

  ptq_tx_unpacker #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_start  (rd_start),
    .rd_ack    (rd_ack),
    .rd_end    (rd_end),
    .rd_eod    (rd_eod),
    .rb_valid  (rb_valid),
    .rb_data   (rb_data),
    .rb_ready  (rb_ready),
    .txd_valid (txd_valid),
    .txd_limit (txd_data[CNT_W-1:0]),
    .txd_ready (txd_ready),
    .txq_valid (txq_valid),
    .txq_data  (txq_data),
    .txq_ready (txq_ready)
  );
endmodule

// File: rtl/ptq_bridge_chk.sv
module ptq_bridge_chk #(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wb_valid,
  input logic              wr_busy,
  input logic              overflow,
  input logic              ovf_clear,
  input logic              rxq_valid,
  input logic [WORD_W-1:0] rxq_data,
  input logic              rxq_ready,
  input logic              rxd_valid,
  input logic [WORD_W-1:0] rxd_data,
  input logic              rxd_ready,
  input logic              rd_start,
  input logic              rd_ack,
  input logic              rd_end,
  input logic              rd_eod,
  input logic              rb_valid,
  input logic [7:0]        rb_data,
  input logic              rb_ready,
  input logic [CNT_W-1:0]  txd_limit,
  input logic              txd_valid,
  input logic              txd_ready
);
  logic [CNT_W-1:0] lim_q, seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_q  <= '0;
      seen_q <= '0;
    end else if (txd_valid && txd_ready) begin
      lim_q  <= txd_limit;
      seen_q <= '0;
    end else if (rb_valid && rb_ready) begin
      seen_q <= seen_q + 1'b1;
    end
  end

  AST_RXQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rxq_valid && !rxq_ready |=> rxq_valid && $stable(rxq_data)); // R7
  AST_RXD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rxd_valid && !rxd_ready |=> rxd_valid && $stable(rxd_data)); // R7
  AST_DESC_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rxd_valid |-> !rxq_valid); // R3
  AST_DESC_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rxd_valid |-> rxd_data[WORD_W-1:CNT_W] == '0); // R3
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow && !ovf_clear |=> overflow); // R5
  AST_BUSY_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_busy && wb_valid && !overflow |=> !overflow); // R6
  AST_POP_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    txd_ready |-> rd_start && rd_ack); // R8
  AST_RB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rb_valid && !rb_ready |=> (rb_valid || rd_end) && $stable(rb_data)); // R9
  AST_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    rb_valid && rb_ready |-> seen_q < lim_q); // R10
  AST_EOD_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_eod |=> !rd_eod && !rb_valid); // R10
endmodule

bind ptq_bridge ptq_bridge_chk #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wb_valid  (wb_valid),
  .wr_busy   (wr_busy),
  .overflow  (overflow),
  .ovf_clear (ovf_clear),
  .rxq_valid (rxq_valid),
  .rxq_data  (rxq_data),
  .rxq_ready (rxq_ready),
  .rxd_valid (rxd_valid),
  .rxd_data  (rxd_data),
  .rxd_ready (rxd_ready),
  .rd_start  (rd_start),
  .rd_ack    (rd_ack),
  .rd_end    (rd_end),
  .rd_eod    (rd_eod),
  .rb_valid  (rb_valid),
  .rb_data   (rb_data),
  .rb_ready  (rb_ready),
  .txd_limit (txd_data[CNT_W-1:0]),
  .txd_valid (txd_valid),
  .txd_ready (txd_ready)
);

// File: tb/ptq_bridge_test.sv
module ptq_bridge_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n;
  logic        wb_valid, wr_end, ovf_clear, rxq_ready, rxd_ready;
  logic [7:0]  wb_data;
  logic        wr_busy, overflow, rxq_valid, rxd_valid;
  logic [31:0] rxq_data, rxd_data;
  logic        rd_start, rd_end, rb_ready;
  logic        rd_ack, rd_eod, rb_valid, txd_ready, txq_ready;
  logic [7:0]  rb_data;
  logic        txd_valid, txq_valid;
  logic [31:0] txd_data, txq_data;

  logic [31:0] txq_mem [32];
  logic [31:0] txd_mem [8];
  int txq_wr = 0, txq_rd = 0, txd_wr = 0, txd_rd = 0;

  assign txq_valid = (txq_rd < txq_wr);
  assign txq_data  = txq_mem[txq_rd % 32];
  assign txd_valid = (txd_rd < txd_wr);
  assign txd_data  = txd_mem[txd_rd % 8];

  always @(posedge clk) begin
    if (txq_valid && txq_ready) txq_rd <= txq_rd + 1;
    if (txd_valid && txd_ready) txd_rd <= txd_rd + 1;
  end

  ptq_bridge uut (
    .clk(clk), .rst_n(rst_n),
    .wb_valid(wb_valid), .wb_data(wb_data), .wr_end(wr_end),
    .wr_busy(wr_busy), .overflow(overflow), .ovf_clear(ovf_clear),
    .rxq_valid(rxq_valid), .rxq_data(rxq_data), .rxq_ready(rxq_ready),
    .rxd_valid(rxd_valid), .rxd_data(rxd_data), .rxd_ready(rxd_ready),
    .rd_start(rd_start), .rd_ack(rd_ack), .rd_end(rd_end), .rd_eod(rd_eod),
    .rb_valid(rb_valid), .rb_data(rb_data), .rb_ready(rb_ready),
    .txd_valid(txd_valid), .txd_data(txd_data), .txd_ready(txd_ready),
    .txq_valid(txq_valid), .txq_data(txq_data), .txq_ready(txq_ready)
  );

  int checks = 0, fails = 0, eod_seen = 0, model_rd = 0;
  bit done = 0;
  string rd_tag = "R9";
  logic [31:0] exp_rxq [$];
  logic [31:0] exp_rxd [$];
  logic [7:0]  exp_rb  [$];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Scoreboard monitor: compares every handshake against the expected queues.
  always @(negedge clk) begin
    if (rst_n) begin
      if (rxq_valid && rxq_ready) begin
        if (exp_rxq.size() == 0) check(0, "R1", "unexpected data word", rxq_data, 32'h0);
        else begin
          automatic logic [31:0] e = exp_rxq.pop_front();
          check(rxq_data == e, "R1", "data word", rxq_data, e);
        end
      end
      if (rxd_valid && rxd_ready) begin
        if (exp_rxd.size() == 0) check(0, "R3", "unexpected descriptor", rxd_data, 32'h0);
        else begin
          automatic logic [31:0] e = exp_rxd.pop_front();
          check(rxd_data == e, "R3", "descriptor", rxd_data, e);
        end
      end
      if (rb_valid && rb_ready) begin
        if (exp_rb.size() == 0) check(0, rd_tag, "unexpected read byte", {24'h0, rb_data}, 32'h0);
        else begin
          automatic logic [7:0] e = exp_rb.pop_front();
          check(rb_data == e, rd_tag, "read byte", {24'h0, rb_data}, {24'h0, e});
        end
      end
      if (rd_eod) eod_seen++;
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  // Driver for one write; gate[i]=0 holds rxq_ready low for byte i.
  task automatic wr_xfer(input logic [7:0] b[$], input bit gate[$],
                         input bit end_with_last, input bit poke_busy);
    logic [31:0] acc = '0;
    int lane = 0, n = 0;
    if (poke_busy) rxd_ready = 1'b0;
    foreach (b[i]) begin
      step();
      wb_valid = 1'b1; wb_data = b[i]; rxq_ready = gate[i];
      wr_end = end_with_last && (i == b.size() - 1);
      if (gate[i]) begin
        if (lane == 0) acc = '0;
        acc[lane*8 +: 8] = b[i];
        lane++; n++;
        if (lane == 4) begin exp_rxq.push_back(acc); lane = 0; end
      end
    end
    if (lane > 0) exp_rxq.push_back(acc);
    exp_rxd.push_back(32'(n));
    step();
    wb_valid = 1'b0; rxq_ready = 1'b1;
    wr_end = !(end_with_last && b.size() > 0);
    if (wr_end) begin step(); wr_end = 1'b0; end
    @(negedge clk);
    check(wr_busy == 1'b1, "R6", "busy after end", {31'h0, wr_busy}, 32'h1);
    if (poke_busy) begin
      step(); wb_valid = 1'b1; wb_data = 8'hEE;
      step(); step(); wb_valid = 1'b0;
      @(negedge clk);
      check(rxd_valid && rxd_data == 32'(n), "R7", "descriptor held", rxd_data, 32'(n));
      check(overflow == 1'b0, "R6", "busy byte set overflow", {31'h0, overflow}, 32'h0);
      step(); rxd_ready = 1'b1;
    end
    for (int t = 0; t < 50 && wr_busy; t++) @(negedge clk);
  endtask

  task automatic do_read(input int limit, input int abort_after, input string tag);
    int avail, nb, e0;
    rd_tag = tag;
    txd_mem[txd_wr % 8] = 32'(limit);
    txd_wr++;
    avail = txq_wr - model_rd;
    nb = (abort_after >= 0) ? abort_after : ((limit < 4 * avail) ? limit : 4 * avail);
    for (int k = 0; k < nb; k++) exp_rb.push_back(txq_mem[(model_rd + k / 4) % 32][(k % 4) * 8 +: 8]);
    model_rd += (nb + 3) / 4;
    e0 = eod_seen;
    step();
    rd_start = 1'b1; rb_ready = (abort_after < 0);
    @(negedge clk);
    check(rd_ack == 1'b1, "R8", "read accepted", {31'h0, rd_ack}, 32'h1);
    step(); rd_start = 1'b0;
    if (abort_after >= 0) begin
      for (int k = 0; k < abort_after; k++) begin
        for (int t = 0; t < 20 && !rb_valid; t++) @(negedge clk);
        step(); rb_ready = 1'b1;
        step(); rb_ready = 1'b0;
      end
      rd_end = 1'b1; step(); rd_end = 1'b0;
      @(negedge clk);
      check(rb_valid == 1'b0, "R12", "byte after abort", {31'h0, rb_valid}, 32'h0);
    end else begin
      for (int t = 0; t < 100 && eod_seen == e0; t++) @(negedge clk);
      check(eod_seen == e0 + 1, tag, "end of data pulse", 32'(eod_seen - e0), 32'h1);
      rb_ready = 1'b0;
    end
    check(exp_rb.size() == 0, tag, "bytes missing", 32'(exp_rb.size()), 32'h0);
    check(txq_rd == model_rd, tag, "words popped", 32'(txq_rd), 32'(model_rd));
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wb_valid = 0; wb_data = 0; wr_end = 0; ovf_clear = 0;
    rxq_ready = 1; rxd_ready = 1; rd_start = 0; rd_end = 0; rb_ready = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(!rxq_valid && !rxd_valid && !rb_valid, "R13", "no offers after reset",
          {29'h0, rxq_valid, rxd_valid, rb_valid}, 32'h0);
    check(!overflow && !wr_busy && !rd_eod, "R13", "status after reset",
          {29'h0, overflow, wr_busy, rd_eod}, 32'h0);

    // R1 R3: two full words, separate end marker
    wr_xfer('{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h77, 8'h88},
            '{1, 1, 1, 1, 1, 1, 1, 1}, 0, 0);
    // R2 R4: end together with the fifth byte, padded word
    wr_xfer('{8'hA1, 8'hA2, 8'hA3, 8'hA4, 8'hA5}, '{1, 1, 1, 1, 1}, 1, 0);
    // R3: empty write
    wr_xfer('{}, '{}, 0, 0);
    // R5: two bytes dropped while the queue is full
    wr_xfer('{8'hC1, 8'hC2, 8'hC3, 8'hC4, 8'hC5, 8'hC6}, '{1, 1, 0, 0, 1, 1}, 0, 0);
    @(negedge clk);
    check(overflow == 1'b1, "R5", "overflow after drop", {31'h0, overflow}, 32'h1);
    step(); ovf_clear = 1'b1; step(); ovf_clear = 1'b0;
    @(negedge clk);
    check(overflow == 1'b0, "R5", "overflow cleared", {31'h0, overflow}, 32'h0);
    // R6 R7: bytes while busy are ignored, descriptor held
    wr_xfer('{8'hD1, 8'hD2, 8'hD3}, '{1, 1, 1}, 0, 1);
    wr_xfer('{8'hE1, 8'hE2, 8'hE3, 8'hE4}, '{1, 1, 1, 1}, 1, 0);
    check(exp_rxq.size() == 0 && exp_rxd.size() == 0, "R3", "write items left",
          32'(exp_rxq.size() + exp_rxd.size()), 32'h0);

    // Read path
    for (int w = 0; w < 5; w++) begin
      txq_mem[txq_wr % 32] = 32'h1020_3040 + 32'(w) * 32'h0101_0101;
      txq_wr++;
    end
    do_read(6, -1, "R10");
    do_read(0, -1, "R10");
    do_read(8, 2, "R12");
    do_read(100, -1, "R11");
    step(); rd_start = 1'b1;
    @(negedge clk);
    check(rd_ack == 1'b0, "R8", "refused without descriptor", {31'h0, rd_ack}, 32'h0);
    step(); rd_start = 1'b0;
    @(negedge clk);
    check(rb_valid == 1'b0 && txd_rd == txd_wr, "R8", "nothing after refusal",
          {31'h0, rb_valid}, 32'h0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule